// File: doc/BRIEF.md
# Dual-Page Serial Register Write Controller

This block is the write side of an on-screen character overlay. A host sends 24-bit frames over a three-wire synchronous serial link: a select line held low for the length of a frame, a serial clock and a data line. Each frame carries a 10-bit address, a page flag and 13 data bits. The block routes the word into one of two character RAM pages, or into a small bank of control registers that exists once per page.

Both pages answer to the same address map, and the page flag picks which copy is written. A few registers hold settings that apply to the whole screen. These exist only in page 0: a page-1 write to them changes nothing, and a page-1 read returns the page-0 copy. The display side fetches character cells by page, row and column through a registered read port. Control logic reads the register bank through a second, combinational read port.

The serial lines are synchronised into the system clock domain. A rising edge of the serial clock is detected there, so the serial clock must run well below the system clock.

Top module: `dpw_serial_writer`

## Requirements
- R1: Bits are shifted in only on a rising serial clock edge while the select line is low. Serial clock edges seen while select is high have no effect on the next frame.
- R2: A frame is 24 bits sent MSB first: bits 23..14 are the address, bit 13 is the page flag (0 = page 0, 1 = page 1) and bits 12..0 are data. The write happens only after the 24th rising edge, and no stored value changes without a completed frame.
- R3: Addresses 0x000..0x11F write the character RAM page chosen by the flag, with the stored word being {2'b00, data}. Pages are independent. Cell (row, col) with 12 rows and 24 columns is address row*24+col. The read port returns the word one system clock after the read inputs are applied.
- R4: Addresses 0x120..0x128 write control register index (address − 0x120) of the flagged page, stored as {2'b00, data}. The configuration read port returns it combinationally.
- R5: Register indices 0 and 1 are page-0-only. A write to them with flag 1 leaves them unchanged, and a page-1 read of them returns the page-0 value.
- R6: Active-low reset clears every control register of both pages to zero and leaves RAM contents untouched.
- R7: Raising select before 24 bits have arrived discards the partial frame, and the next frame starts from bit 23.
- R8: A frame with an address above 0x128 changes no register and no RAM word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| ser_sel_n | input | 1 | Serial frame select, active low |
| ser_clk | input | 1 | Serial bit clock, data taken on its rising edge |
| ser_dat | input | 1 | Serial data in, MSB first |
| rd_page | input | 1 | Page of the character cell to read |
| rd_row | input | 4 | Row of the cell, 0..11 |
| rd_col | input | 5 | Column of the cell, 0..23 |
| rd_word | output | 15 | Cell contents, one clock after the read inputs |
| cfg_page | input | 1 | Page of the control register to read |
| cfg_idx | input | 4 | Control register index, 0..8 |
| cfg_word | output | 15 | Control register contents, combinational |

## Verification
Two functions can meet in one cycle. A frame can complete while the display side is reading the same cell, and a page-1 frame can target a shared register that is also being read through the page-1 view. The bench reads a cell immediately after its frame completes. It also reads both views of a shared register right after a page-1 write to it, and requires the page-0 value in each case. Expected values come from a page-aware model in the bench that applies the shared-register rule itself.

// File: rtl/dpw_pkg.sv
package dpw_pkg;
    localparam int ADDR_W    = 10;
    localparam int DATA_W    = 13;
    localparam int WORD_W    = 15;
    localparam int FRAME_W   = ADDR_W + 1 + DATA_W;
    localparam int ROWS      = 12;
    localparam int COLS      = 24;
    localparam int RAM_DEPTH = ROWS * COLS;
    localparam int RAM_AW    = $clog2(RAM_DEPTH);
    localparam int ROW_W     = $clog2(ROWS);
    localparam int COL_W     = $clog2(COLS);
    localparam int NUM_REGS  = 9;
    localparam int IDX_W     = $clog2(NUM_REGS);
    localparam logic [ADDR_W-1:0] REG_BASE = 10'h120;
    localparam logic [ADDR_W-1:0] REG_LAST = REG_BASE + ADDR_W'(NUM_REGS - 1);
    localparam logic [ADDR_W-1:0] RAM_LAST = ADDR_W'(RAM_DEPTH - 1);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              page;
        logic [DATA_W-1:0] data;
    } frame_t;
endpackage

// File: rtl/dpw_rx.sv
module dpw_rx
    import dpw_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   sel_n,
    input  logic   sclk,
    input  logic   sdat,
    output logic   frm_vld,
    output frame_t frm,
    output logic   link_act
);
    localparam int CNT_W = $clog2(FRAME_W);

    typedef struct packed {
        logic [2:0]         clk_s;
        logic [1:0]         sel_s;
        logic [1:0]         dat_s;
        logic [FRAME_W-1:0] shift;
        logic [CNT_W-1:0]   cnt;
        logic               vld;
    } rx_state_t;

    rx_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.vld   = 1'b0;
        st_d.clk_s = {st_q.clk_s[1:0], sclk};
        st_d.sel_s = {st_q.sel_s[0], sel_n};
        st_d.dat_s = {st_q.dat_s[0], sdat};
        if (st_q.sel_s[1]) begin
            st_d.cnt = '0;
        end else if (st_q.clk_s[1] && !st_q.clk_s[2]) begin
            st_d.shift = {st_q.shift[FRAME_W-2:0], st_q.dat_s[1]};
            if (st_q.cnt == CNT_W'(FRAME_W - 1)) begin
                st_d.cnt = '0;
                st_d.vld = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.sel_s <= 2'b11;
        end else begin
            st_q <= st_d;
        end
    end

    assign frm_vld  = st_q.vld;
    assign frm      = frame_t'(st_q.shift);
    assign link_act = !st_q.sel_s[1];
endmodule

// File: rtl/dpw_ram.sv
module dpw_ram
    import dpw_pkg::*;
#(
    parameter int DEPTH = RAM_DEPTH,
    parameter int AW    = RAM_AW,
    parameter int W     = WORD_W
) (
    input  logic          clk,
    input  logic          we,
    input  logic          wpage,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic          rpage,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    logic [W-1:0] pg_out [2];

    for (genvar p = 0; p < 2; p++) begin : g_page
        logic [W-1:0] cells [DEPTH];
        always_ff @(posedge clk) begin
            if (we && (wpage == 1'(p))) begin
                cells[waddr] <= wdata;
            end
        end
        assign pg_out[p] = cells[raddr];
    end

    always_ff @(posedge clk) begin
        rdata <= pg_out[rpage];
    end
endmodule

// File: rtl/dpw_regs.sv
module dpw_regs
    import dpw_pkg::*;
#(
    parameter logic [NUM_REGS-1:0] SHARED = 9'b0_0000_0011
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       we,
    input  logic                       page,
    input  logic [IDX_W-1:0]           idx,
    input  logic [WORD_W-1:0]          wdata,
    input  logic                       rd_page,
    input  logic [IDX_W-1:0]           rd_idx,
    output logic [WORD_W-1:0]          rd_word,
    output logic [NUM_REGS*WORD_W-1:0] p0_flat,
    output logic [NUM_REGS*WORD_W-1:0] p1_flat,
    output logic                       any_set
);
    typedef struct packed {
        logic [NUM_REGS-1:0][WORD_W-1:0] pg0;
        logic [NUM_REGS-1:0][WORD_W-1:0] pg1;
    } bank_t;

    bank_t bk_d, bk_q;
    logic [WORD_W-1:0] view1 [NUM_REGS];

    always_comb begin
        bk_d = bk_q;
        if (we && (idx < IDX_W'(NUM_REGS))) begin
            if (!page) begin
                bk_d.pg0[idx] = wdata;
            end else if (!SHARED[idx]) begin
                bk_d.pg1[idx] = wdata;
            end
        end
        for (int i = 0; i < NUM_REGS; i++) begin
            if (SHARED[i]) bk_d.pg1[i] = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bk_q <= '0;
        else        bk_q <= bk_d;
    end

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_view
        if (SHARED[i]) begin : g_sh
            assign view1[i] = bk_q.pg0[i];
        end else begin : g_own
            assign view1[i] = bk_q.pg1[i];
        end
    end

    always_comb begin
        rd_word = '0;
        if (rd_idx < IDX_W'(NUM_REGS)) begin
            rd_word = rd_page ? view1[rd_idx] : bk_q.pg0[rd_idx];
        end
    end

    assign p0_flat = bk_q.pg0;
    assign p1_flat = bk_q.pg1;
    assign any_set = (|bk_q.pg0) | (|bk_q.pg1);
endmodule

// File: rtl/dpw_serial_writer.sv
module dpw_serial_writer
    import dpw_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_sel_n,
    input  logic              ser_clk,
    input  logic              ser_dat,
    input  logic              rd_page,
    input  logic [ROW_W-1:0]  rd_row,
    input  logic [COL_W-1:0]  rd_col,
    output logic [WORD_W-1:0] rd_word,
    input  logic              cfg_page,
    input  logic [IDX_W-1:0]  cfg_idx,
    output logic [WORD_W-1:0] cfg_word
);
    logic                       frm_vld;
    frame_t                     frm;
    logic                       link_act;
    logic                       ram_we;
    logic                       reg_we;
    logic [IDX_W-1:0]           reg_idx;
    logic [RAM_AW-1:0]          cell_addr;
    logic [WORD_W-1:0]          wr_word;
    logic [NUM_REGS*WORD_W-1:0] p0_flat;
    logic [NUM_REGS*WORD_W-1:0] p1_flat;
    logic                       any_set;

    dpw_rx u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel_n    (ser_sel_n),
        .sclk     (ser_clk),
        .sdat     (ser_dat),
        .frm_vld  (frm_vld),
        .frm      (frm),
        .link_act (link_act)
    );

    always_comb begin
        wr_word   = {{(WORD_W-DATA_W){1'b0}}, frm.data};
        ram_we    = frm_vld && (frm.addr <= RAM_LAST);
        reg_we    = frm_vld && (frm.addr >= REG_BASE) && (frm.addr <= REG_LAST);
        reg_idx   = IDX_W'(frm.addr - REG_BASE);
        cell_addr = RAM_AW'(rd_row) * RAM_AW'(COLS) + RAM_AW'(rd_col);
    end

    dpw_ram u_ram (
        .clk   (clk),
        .we    (ram_we),
        .wpage (frm.page),
        .waddr (frm.addr[RAM_AW-1:0]),
        .wdata (wr_word),
        .rpage (rd_page),
        .raddr (cell_addr),
        .rdata (rd_word)
    );

    dpw_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (reg_we),
        .page    (frm.page),
        .idx     (reg_idx),
        .wdata   (wr_word),
        .rd_page (cfg_page),
        .rd_idx  (cfg_idx),
        .rd_word (cfg_word),
        .p0_flat (p0_flat),
        .p1_flat (p1_flat),
        .any_set (any_set)
    );
endmodule

// File: rtl/dpw_sva.sv
module dpw_sva
    import dpw_pkg::*;
(
    input logic                       clk,
    input logic                       rst_n,
    input logic                       frm_vld,
    input logic [ADDR_W-1:0]          frm_addr,
    input logic                       frm_page,
    input logic [DATA_W-1:0]          frm_data,
    input logic                       link_act,
    input logic [NUM_REGS*WORD_W-1:0] p0_flat,
    input logic [NUM_REGS*WORD_W-1:0] p1_flat,
    input logic                       any_set
);
    logic [IDX_W-1:0]  idx_c;
    logic [IDX_W-1:0]  idx_l;
    logic [WORD_W-1:0] exp_l;
    logic              p0_hit;

    assign idx_c  = IDX_W'(frm_addr - REG_BASE);
    assign p0_hit = frm_vld && !frm_page && (frm_addr >= REG_BASE) && (frm_addr <= REG_LAST);

    always_ff @(posedge clk) begin
        idx_l <= idx_c;
        exp_l <= {{(WORD_W-DATA_W){1'b0}}, frm_data};
    end

    assert_frame_needs_select_R1: assert property (@(posedge clk) disable iff (!rst_n)
        frm_vld |-> $past(link_act));

    assert_no_change_without_frame_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !frm_vld |=> ($stable(p0_flat) && $stable(p1_flat)));

    assert_page0_write_lands_R4: assert property (@(posedge clk) disable iff (!rst_n)
        p0_hit |=> (p0_flat[int'(idx_l)*WORD_W +: WORD_W] == exp_l));

    assert_page1_spares_page0_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_vld && frm_page) |=> $stable(p0_flat));

    assert_reset_clears_R6: assert property (@(posedge clk)
        !rst_n |=> !any_set);

    assert_high_addr_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_vld && (frm_addr > REG_LAST)) |=> ($stable(p0_flat) && $stable(p1_flat)));
endmodule

bind dpw_serial_writer dpw_sva u_sva (
    .clk      (clk),
    .rst_n    (rst_n),
    .frm_vld  (frm_vld),
    .frm_addr (frm.addr),
    .frm_page (frm.page),
    .frm_data (frm.data),
    .link_act (link_act),
    .p0_flat  (p0_flat),
    .p1_flat  (p1_flat),
    .any_set  (any_set)
);

// File: tb/dpw_serial_writer_bench.sv
module dpw_serial_writer_bench;
    localparam int CLK_PERIOD = 10;
    localparam int HALF_BIT   = 4;
    localparam int NVEC       = 11;
    localparam logic [23:0] VEC [NVEC] = '{
        {10'h000, 1'b0, 13'h0141},
        {10'h000, 1'b1, 13'h1ABC},
        {10'h11F, 1'b0, 13'h1FFF},
        {10'h05A, 1'b1, 13'h0003},
        {10'h122, 1'b0, 13'h1234},
        {10'h122, 1'b1, 13'h0F0F},
        {10'h120, 1'b0, 13'h1555},
        {10'h120, 1'b1, 13'h0AAA},
        {10'h128, 1'b1, 13'h1001},
        {10'h129, 1'b0, 13'h1FFF},
        {10'h3FF, 1'b1, 13'h1FFF}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ser_sel_n = 1'b1;
    logic        ser_clk = 1'b0;
    logic        ser_dat = 1'b0;
    logic        rd_page = 1'b0;
    logic [3:0]  rd_row = '0;
    logic [4:0]  rd_col = '0;
    logic [14:0] rd_word;
    logic        cfg_page = 1'b0;
    logic [3:0]  cfg_idx = '0;
    logic [14:0] cfg_word;

    int n_chk  = 0;
    int n_fail = 0;
    logic [14:0] mreg [2][9];

    always #(CLK_PERIOD/2) clk = ~clk;

    dpw_serial_writer u_dpw_serial_writer (
        .clk(clk), .rst_n(rst_n), .ser_sel_n(ser_sel_n), .ser_clk(ser_clk),
        .ser_dat(ser_dat), .rd_page(rd_page), .rd_row(rd_row), .rd_col(rd_col),
        .rd_word(rd_word), .cfg_page(cfg_page), .cfg_idx(cfg_idx), .cfg_word(cfg_word)
    );

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input string what, input logic [14:0] act, input logic [14:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic shift_bits(input logic [23:0] f, input int n);
        ser_sel_n = 1'b0;
        wait_clk(HALF_BIT);
        for (int i = 0; i < n; i++) begin
            ser_dat = f[23-i];
            wait_clk(HALF_BIT);
            ser_clk = 1'b1;
            wait_clk(HALF_BIT);
            ser_clk = 1'b0;
        end
        wait_clk(8);
        ser_sel_n = 1'b1;
        wait_clk(HALF_BIT);
    endtask

    function automatic void model_write(input logic [23:0] f);
        logic [9:0] a = f[23:14];
        logic       p = f[13];
        if (a >= 10'h120 && a <= 10'h128) begin
            if (!(p && (a - 10'h120) < 2)) mreg[p][a - 10'h120] = {2'b00, f[12:0]};
        end
    endfunction

    function automatic logic [14:0] model_cfg(input logic p, input int i);
        return (i < 2) ? mreg[0][i] : mreg[p][i];
    endfunction

    task automatic read_cell(input logic p, input int addr, output logic [14:0] w);
        rd_page = p;
        rd_row  = 4'(addr / 24);
        rd_col  = 5'(addr % 24);
        wait_clk(2);
        w = rd_word;
    endtask

    task automatic check_regs(input string req);
        for (int p = 0; p < 2; p++) begin
            for (int i = 0; i < 9; i++) begin
                cfg_page = 1'(p);
                cfg_idx  = 4'(i);
                #1;
                chk(req, $sformatf("cfg p%0d i%0d", p, i), cfg_word, model_cfg(1'(p), i));
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [14:0] w;
        for (int p = 0; p < 2; p++) for (int i = 0; i < 9; i++) mreg[p][i] = '0;
        wait_clk(4);
        rst_n = 1'b1;
        wait_clk(2);
        check_regs("R6");

        for (int v = 0; v < NVEC; v++) begin
            logic [9:0] a;
            a = VEC[v][23:14];
            shift_bits(VEC[v], 24);
            model_write(VEC[v]);
            if (a <= 10'h11F) begin
                read_cell(VEC[v][13], int'(a), w);
                chk("R3", $sformatf("cell %h", a), w, {2'b00, VEC[v][12:0]});
            end else if (a > 10'h128) begin
                check_regs("R8");
            end else if (VEC[v][13] && (a - 10'h120) < 2) begin
                check_regs("R5");
            end else begin
                check_regs("R4");
            end
        end

        read_cell(1'b0, 0, w);
        chk("R3", "page0 cell 0 isolated", w, 15'h0141);
        read_cell(1'b1, 0, w);
        chk("R3", "page1 cell 0 isolated", w, 15'h1ABC);
        read_cell(1'b0, 287, w);
        chk("R3", "last cell row11 col23", w, 15'h1FFF);

        ser_dat = 1'b1;
        for (int k = 0; k < 5; k++) begin
            wait_clk(HALF_BIT); ser_clk = 1'b1;
            wait_clk(HALF_BIT); ser_clk = 1'b0;
        end
        shift_bits({10'h125, 1'b1, 13'h0C3A}, 24);
        model_write({10'h125, 1'b1, 13'h0C3A});
        cfg_page = 1'b1; cfg_idx = 4'd5; #1;
        chk("R1", "clocks with select high ignored", cfg_word, 15'h0C3A);

        shift_bits({10'h124, 1'b0, 13'h1FFF}, 10);
        chk("R7", "partial frame not written", cfg_word, model_cfg(1'b1, 5));
        cfg_page = 1'b0; cfg_idx = 4'd4; #1;
        chk("R7", "partial frame no reg effect", cfg_word, 15'h0000);
        shift_bits({10'h124, 1'b0, 13'h0765}, 24);
        model_write({10'h124, 1'b0, 13'h0765});
        cfg_page = 1'b0; cfg_idx = 4'd4; #1;
        chk("R7", "frame after abort aligned", cfg_word, 15'h0765);

        shift_bits({10'h121, 1'b0, 13'h0B0B}, 23);
        check_regs("R2");

        shift_bits({10'h0A0, 1'b1, 13'h0777}, 24);
        rst_n = 1'b0;
        wait_clk(3);
        for (int p = 0; p < 2; p++) for (int i = 0; i < 9; i++) mreg[p][i] = '0;
        check_regs("R6");
        rst_n = 1'b1;
        wait_clk(2);
        read_cell(1'b1, 160, w);
        chk("R6", "RAM kept across reset", w, 15'h0777);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule